// File: doc/BRIEF.md
# Cascadable Serial Result Output Port

This block is the converter-side serial slave port that hands a finished 16-bit result to a host over a single data line. The host supplies the serial clock, a chip select and a read strobe. When the converter core drops its busy flag, the new result is captured and presented most significant bit first. Each shift edge of the serial clock then moves the next bit to the output.

Several converters can share one data line. Each port samples a cascade input on the clock edge opposite to its shift edge and appends those bits behind its own least significant bit. The serial data output of an upstream port is wired to the cascade input of the next port. The host then receives one contiguous stream: the local word first, then the upstream word. A polarity input swaps the roles of the two clock edges, so a gated clock may idle high or low.

The external pins are brought into the core clock domain through synchronisers. The serial clock is oversampled, and its edges are detected in the core clock domain. The output enable is a separate signal, which the pad ring uses for tri-stating.

Top module: `ser_cascade_port`

## Requirements
- R1: After reset the output enable and the data output are low. A read made before any conversion has finished returns zeros.
- R2: On the falling edge of the busy flag the result word is captured, and the data output presents bit 15. This also happens while a read is in progress, and the read then restarts with the new word.
- R3: With the polarity input low, the output advances one bit on each falling serial-clock edge, most significant bit first. Sixteen pulses transfer the whole word.
- R4: With the polarity input low, the cascade input is sampled on each rising serial-clock edge and enters at the least significant end. After pulse 16 the output shows the first upstream bit. Two ports therefore give an unbroken 32-bit stream.
- R5: With the polarity input high, the edges swap. Data shifts on rising edges, and the cascade input is sampled on falling edges. The clock idles high.
- R6: Serial-clock edges while chip select is high have no effect. The next selected read starts again at bit 15 of the last captured word.
- R7: The output enable is high only while both chip select and read are low. Whenever it is low, the data output is held at 0.
- R8: With read high and chip select low, clock pulses still advance the shift position. When read then goes low, the output shows the bit reached at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that oversamples the pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | WORD_W | Result word from the converter core |
| busy_i | input | 1 | Conversion in progress, synchronous to clk_i |
| cs_ni | input | 1 | Active-low chip select from the host |
| rd_ni | input | 1 | Active-low read from the host |
| sclk_i | input | 1 | External serial clock |
| sclk_inv_i | input | 1 | Edge polarity select (0: shift on fall, 1: shift on rise) |
| sdin_i | input | 1 | Cascade serial input from the upstream port |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable for the data pad |

## Verification
The checks assume the following about the inputs:
- The serial clock is slow next to the core clock, so two detected edges never fall on adjacent cycles.
- The polarity input stays fixed while chip select is low.
- Chip select never moves in the same cycle as a serial-clock edge.

The stimulus meets these assumptions:
- Every serial-clock level is held for six core cycles.
- Chip select changes only when no edge is in flight.
- Polarity changes only while the port is deselected.
- The cascade input changes two cycles before the edge that samples it.

// File: rtl/ser_cascade_pkg.sv
package ser_cascade_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic shift;
    logic latch;
  } sclk_evt_t;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= RST_VAL;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core
  import ser_cascade_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              sel_i,
  input  sclk_evt_t         evt_i,
  input  logic              casc_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] result_q, word_q;
  logic              casc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      word_q   <= '0;
    end else if (load_i) begin
      result_q <= data_i;
      word_q   <= data_i;
    end else if (!sel_i) begin
      word_q   <= result_q;  // rewind to bit MSB
    end else if (evt_i.shift) begin
      word_q   <= {word_q[WORD_W-2:0], casc_q};
    end
  end

  // cascade bit held between latch edge and shift edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) casc_q <= 1'b0;
    else if (!sel_i) casc_q <= 1'b0;
    else if (evt_i.latch) casc_q <= casc_i;
  end

  assign msb_o = word_q[WORD_W-1];

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (word_q == $past(data_i)) && (result_q == $past(data_i)));

  a_r3_shift_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && evt_i.shift && !load_i) |=> word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0]));

  a_r4_append_cascade: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && evt_i.shift && !load_i) |=> word_q[0] == $past(casc_q));

  a_r6_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !load_i) |=> word_q == $past(result_q));
endmodule

// File: rtl/ser_cascade_port.sv
module ser_cascade_port
  import ser_cascade_pkg::*;
#(
  parameter int unsigned WORD_W      = DEF_WORD_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              busy_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              sclk_i,
  input  logic              sclk_inv_i,
  input  logic              sdin_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned PIN_W = 4;

  logic [PIN_W-1:0] pins_s;
  logic cs_s, rd_s, sclk_s, sdin_s;
  logic sclk_prev_q, busy_q;
  logic sclk_rise, sclk_fall, busy_fall, msb;
  sclk_evt_t evt;

  ser_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1100)
  ) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, rd_ni, sclk_i, sdin_i}),
    .q_o   (pins_s)
  );

  assign {cs_s, rd_s, sclk_s, sdin_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      busy_q      <= busy_i;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
  assign busy_fall = busy_q & ~busy_i;

  // clock gated by chip select; polarity swaps edge roles
  assign evt.shift = ~cs_s & (sclk_inv_i ? sclk_rise : sclk_fall);
  assign evt.latch = ~cs_s & (sclk_inv_i ? sclk_fall : sclk_rise);

  ser_shift_core #(.WORD_W(WORD_W)) i_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(busy_fall),
    .data_i(data_i),
    .sel_i (~cs_s),
    .evt_i (evt),
    .casc_i(sdin_s),
    .msb_o (msb)
  );

  assign sdo_oe_o = ~cs_s & ~rd_s;
  assign sdo_o    = sdo_oe_o & msb;

  a_r5_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt.shift && evt.latch));

  a_r6_deaf_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> !(evt.shift || evt.latch));

  a_r7_quiet_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);

  a_r3_sclk_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise || sclk_fall) |=> !(sclk_rise || sclk_fall));
endmodule

// File: tb/test_ser_cascade_port.sv
module test_ser_cascade_port;
  localparam int W = 16;
  localparam int H = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic busy_i = 1'b0, cs_ni = 1'b1, rd_ni = 1'b1;
  logic sclk_i = 1'b0, sclk_inv_i = 1'b0, sdin_i = 1'b0;
  logic sdo_o, sdo_oe_o;
  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  ser_cascade_port i_ser_cascade_port (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .busy_i(busy_i),
    .cs_ni(cs_ni), .rd_ni(rd_ni), .sclk_i(sclk_i), .sclk_inv_i(sclk_inv_i),
    .sdin_i(sdin_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic convert(logic [W-1:0] w);
    data_i = w; busy_i = 1'b1;
    wait_clk(3);
    busy_i = 1'b0;
    wait_clk(4);
  endtask

  task automatic select(bit on);
    cs_ni = !on;
    wait_clk(H);
  endtask

  // sample, set cascade bit, latch edge, shift edge
  task automatic clk_bits(string tag, logic [63:0] exp_s, logic [63:0] up_s, int n, bit chk);
    for (int k = 0; k < n; k++) begin
      if (chk) check(tag, sdo_o, exp_s[63-k]);
      sdin_i = up_s[63-k];
      wait_clk(2);
      sclk_i = ~sclk_inv_i;
      wait_clk(H);
      sclk_i = sclk_inv_i;
      wait_clk(H);
    end
  endtask

  task automatic t_reset();
    check("R1 oe after reset", sdo_oe_o, 1'b0);
    check("R1 sdo after reset", sdo_o, 1'b0);
    rd_ni = 1'b0;
    select(1);
    check("R1 oe selected", sdo_oe_o, 1'b1);
    clk_bits("R1 empty word", 64'h0, 64'h0, 4, 1);
    select(0);
  endtask

  task automatic t_basic();
    convert(16'hA5C3);
    select(1);
    check("R2 first bit", sdo_o, 1'b1);
    clk_bits("R3 msb first", {16'hA5C3, 48'h0}, 64'h0, 17, 1);
    select(0);
  endtask

  task automatic t_cascade();
    convert(16'h1234);
    select(1);
    clk_bits("R4 cascade pol0", {16'h1234, 16'hBEEF, 32'h0}, {16'hBEEF, 48'h0}, 32, 1);
    select(0);
  endtask

  task automatic t_inverted();
    sclk_inv_i = 1'b1; sclk_i = 1'b1;
    wait_clk(H);
    convert(16'hF00F);
    select(1);
    clk_bits("R5 cascade pol1", {16'hF00F, 16'h5A5A, 32'h0}, {16'h5A5A, 48'h0}, 32, 1);
    select(0);
    sclk_inv_i = 1'b0; sclk_i = 1'b0;
    wait_clk(H);
  endtask

  task automatic t_deselect();
    convert(16'h9C3E);
    select(1);
    clk_bits("R6 partial", {16'h9C3E, 48'h0}, 64'h0, 5, 1);
    select(0);
    for (int p = 0; p < 4; p++) begin
      sclk_i = 1'b1; wait_clk(H);
      sclk_i = 1'b0; wait_clk(H);
    end
    select(1);
    clk_bits("R6 restart", {16'h9C3E, 48'h0}, 64'h0, 16, 1);
    select(0);
  endtask

  task automatic t_rd_gate();
    convert(16'h6D21);
    rd_ni = 1'b1;
    select(1);
    check("R7 oe with rd high", sdo_oe_o, 1'b0);
    check("R7 sdo with rd high", sdo_o, 1'b0);
    clk_bits("R8 hidden", 64'h0, 64'h0, 8, 0);
    check("R7 still disabled", sdo_oe_o, 1'b0);
    check("R7 still quiet", sdo_o, 1'b0);
    rd_ni = 1'b0;
    wait_clk(H);
    check("R7 oe with rd low", sdo_oe_o, 1'b1);
    clk_bits("R8 resumed position", {8'h21, 56'h0}, 64'h0, 8, 1);
    select(0);
    check("R7 oe deselected", sdo_oe_o, 1'b0);
  endtask

  task automatic t_reload();
    convert(16'h0F0F);
    select(1);
    clk_bits("R2 old word", {16'h0F0F, 48'h0}, 64'h0, 3, 1);
    convert(16'h8421);
    clk_bits("R2 reload mid-read", {16'h8421, 48'h0}, 64'h0, 16, 1);
    select(0);
  endtask

  initial begin
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(3);
    t_reset();
    t_basic();
    t_cascade();
    t_inverted();
    t_deselect();
    t_rd_gate();
    t_reload();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule